// File: doc/BRIEF.md
# Split Request/Response Port Adapter

This block sits between an initiator port whose command path and answer path are two fully independent handshakes and a plain synchronous memory-style target. On the command side, the initiator raises `req_valid` and the adapter raises `req_ready`. On the answer side, the adapter raises `rsp_valid` and the initiator raises `rsp_ready`. A transfer on either side happens on each rising clock edge where both of that side's signals are high.

Each accepted command is passed straight to the target in the same cycle through a one-cycle strobe. For a read, the target's data is captured on the following edge into a small response FIFO. Commands carry no tag, so answers leave the FIFO in exactly the order the reads were accepted. The initiator may leave `rsp_ready` low for as long as it likes. While it does, the adapter holds the head answer and, once all slots are spoken for, stops taking commands.

Back-pressure rules: `req_ready` does not depend on `req_valid`. `rsp_valid` does not depend on `rsp_ready`. Once `rsp_valid` is raised, it stays high with unchanged data until it is taken.

Top module: `split_port_adapter`

## Requirements
- R1: A command is taken only on an edge where `req_valid` and `req_ready` are both high. In that same cycle `tgt_en` is high and `tgt_we`, `tgt_addr` and `tgt_wdata` equal `req_write`, `req_addr` and `req_wdata`. In every other cycle `tgt_en` is low.
- R2: A command with `req_write`=1 is a write. It is complete when taken and never produces an answer on the response side.
- R3: A command with `req_write`=0 is a read. It produces exactly one answer, carrying the `tgt_rdata` value present in the cycle after the read was taken. `rsp_valid` rises no later than two cycles after the read is taken.
- R4: Answers leave in the order their reads were taken, whatever the stall pattern on `rsp_ready`.
- R5: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_rdata` stays unchanged on the next cycle.
- R6: Reads that are taken but not yet handed out never exceed `DEPTH`. When `DEPTH` of them are outstanding, `req_ready` is low for reads and writes alike.
- R7: When the adapter is full, one answer handed out makes `req_ready` high again in the next cycle.
- R8: While `rst_n` is low, `req_ready` and `rsp_valid` are low and the FIFO is emptied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Initiator offers a command |
| req_ready | output | 1 | Adapter takes the command on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Command address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Answer available |
| rsp_ready | input | 1 | Initiator takes the answer on this edge |
| rsp_rdata | output | DW | Answer data |
| tgt_en | output | 1 | Target access strobe |
| tgt_we | output | 1 | Target write enable |
| tgt_addr | output | AW | Target address |
| tgt_wdata | output | DW | Target write data |
| tgt_rdata | input | DW | Target read data, valid the cycle after a read strobe |

## Verification
The bound checker tests, on every cycle, the local handshake rules. These are the forwarding of taken commands to the target, the hold of a stalled answer, the cap on outstanding reads, the return of `req_ready` after a pop while full, the absence of answers for writes, and the quiet outputs during reset. Whether each answer carries the right data, in the right order, is something only the bench scoreboard can show. This includes reads that follow a write to the same address and long streams under irregular `rsp_ready` stalls.

// File: rtl/spa_pkg.sv
package spa_pkg;
  typedef enum logic {
    SPA_OP_READ  = 1'b0,
    SPA_OP_WRITE = 1'b1
  } spa_op_e;

  function automatic spa_op_e spa_decode(input logic wr);
    return wr ? SPA_OP_WRITE : SPA_OP_READ;
  endfunction
endpackage

// File: rtl/spa_resp_fifo.sv
module spa_resp_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [LW-1:0] level,
  output logic [DW-1:0] head
);
  logic [DW-1:0] slots [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] level_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   level_q <= level_q + LW'(1);
        2'b01:   level_q <= level_q - LW'(1);
        default: level_q <= level_q;
      endcase
    end
  end

  assign level = level_q;
  assign head  = slots[rd_ptr];
endmodule

// File: rtl/spa_req_stage.sv
module spa_req_stage
  import spa_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [LW-1:0] fifo_level,
  output logic          req_ready,
  output logic          tgt_en,
  output logic          tgt_we,
  output logic [AW-1:0] tgt_addr,
  output logic [DW-1:0] tgt_wdata,
  output logic          cap_en
);
  logic    live_q;
  logic    pend_q;
  logic    take;
  spa_op_e op;
  logic [LW:0] reserve;

  assign op      = spa_decode(req_write);
  assign reserve = {1'b0, fifo_level} + (LW+1)'(pend_q);
  assign req_ready = rst_n && live_q && (reserve < (LW+1)'(DEPTH));
  assign take    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
      pend_q <= take && (op == SPA_OP_READ);
    end
  end

  assign tgt_en    = take;
  assign tgt_we    = take && (op == SPA_OP_WRITE);
  assign tgt_addr  = req_addr;
  assign tgt_wdata = req_wdata;
  assign cap_en    = pend_q;
endmodule

// File: rtl/split_port_adapter.sv
module split_port_adapter #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          tgt_en,
  output logic          tgt_we,
  output logic [AW-1:0] tgt_addr,
  output logic [DW-1:0] tgt_wdata,
  input  logic [DW-1:0] tgt_rdata
);
  logic [LW-1:0] level;
  logic          cap_en;
  logic          pop;

  assign rsp_valid = rst_n && (level != '0);
  assign pop       = rsp_valid && rsp_ready;

  spa_req_stage #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_req (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .fifo_level(level), .req_ready(req_ready),
    .tgt_en(tgt_en), .tgt_we(tgt_we), .tgt_addr(tgt_addr),
    .tgt_wdata(tgt_wdata), .cap_en(cap_en)
  );

  spa_resp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(cap_en), .push_data(tgt_rdata),
    .pop(pop), .level(level), .head(rsp_rdata)
  );
endmodule

// File: rtl/spa_checker.sv
module spa_checker #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_wdata,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_rdata,
  input logic          tgt_en,
  input logic          tgt_we,
  input logic [AW-1:0] tgt_addr,
  input logic [DW-1:0] tgt_wdata
);
  logic [CW-1:0] owed;
  logic rd_take, hand;

  assign rd_take = req_valid && req_ready && !req_write;
  assign hand    = rsp_valid && rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) owed <= '0;
    else owed <= owed + CW'(rd_take) - CW'(hand);
  end

  AST_TGT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (tgt_en && tgt_we == req_write && tgt_addr == req_addr
                                  && tgt_wdata == req_wdata)); // R1
  AST_TGT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |-> !tgt_en); // R1
  AST_NO_WRITE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (owed != '0)); // R2
  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |=> ##1 rsp_valid); // R3
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= CW'(DEPTH)); // R6
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (owed == CW'(DEPTH)) |-> !req_ready); // R6
  AST_READY_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (owed == CW'(DEPTH) && hand) |=> req_ready); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!req_ready && !rsp_valid)); // R8
endmodule

bind split_port_adapter spa_checker #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .tgt_en(tgt_en), .tgt_we(tgt_we), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata)
);

// File: tb/split_port_adapter_test.sv
`timescale 1ns/100ps
module split_port_adapter_test;
  localparam int AW = 8, DW = 32, DEPTH = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, tgt_en, tgt_we;
  logic [DW-1:0] rsp_rdata, tgt_wdata;
  logic [DW-1:0] tgt_rdata = '0;
  logic [AW-1:0] tgt_addr;

  int checks = 0, fails = 0, strobe_bad = 0, popped = 0;
  logic [DW-1:0] expq[$];
  logic [DW-1:0] tmem [16];
  logic [DW-1:0] shadow [16];

  always #2 clk = ~clk;

  split_port_adapter #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) uut (.*);

  // target: synchronous memory, read data one cycle after strobe
  always @(posedge clk) if (tgt_en) begin
    if (tgt_we) tmem[tgt_addr[3:0]] <= tgt_wdata;
    else tgt_rdata <= tmem[tgt_addr[3:0]];
  end

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: issues one command and records the expected answer (R2, R3)
  task automatic send(input logic wr, input logic [3:0] a, input logic [DW-1:0] d);
    bit got;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = d;
    forever begin
      #0.5 got = req_ready;
      @(posedge clk);
      if (got) break;
      @(negedge clk);
    end
    if (wr) shadow[a] = d;
    else expq.push_back(shadow[a]);
    @(negedge clk);
    req_valid = 0;
  endtask

  // monitor: scoreboard comparison and strobe watch
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (tgt_en !== (req_valid && req_ready)) strobe_bad++;
      if (rsp_valid && rsp_ready) begin
        popped++;
        if (expq.size() == 0) check(0, "R2 unexpected answer", rsp_rdata, '0);
        else begin
          logic [DW-1:0] e;
          e = expq.pop_front();
          check(rsp_rdata == e, "R3/R4 answer order/data", rsp_rdata, e);
        end
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int acc;
    for (int i = 0; i < 16; i++) begin
      tmem[i] = 32'hA500_0000 + i * 32'h111;
      shadow[i] = tmem[i];
    end
    repeat (3) @(negedge clk);
    #1 check(!req_ready && !rsp_valid, "R8 reset quiet", {req_ready, rsp_valid}, 0);
    @(negedge clk) rst_n = 1;
    rsp_ready = 1;

    // R2: writes only, then no answer appears
    for (int i = 0; i < 6; i++) send(1, 4'(i), 32'h1000 + i);
    repeat (5) @(negedge clk);
    #1 check(!rsp_valid && expq.size() == 0, "R2 writes silent", rsp_valid, 0);
    // R3: read back, plus read right after a write to the same address
    for (int i = 0; i < 6; i++) send(0, 4'(i), '0);
    send(1, 4'd7, 32'hBEEF_0007);
    send(0, 4'd7, '0);
    send(0, 4'd9, '0);
    repeat (6) @(negedge clk);
    check(expq.size() == 0, "R3 all reads answered", expq.size(), 0);

    // R6: stall answers, hold read requests, expect exactly DEPTH taken
    @(negedge clk) rsp_ready = 0;
    acc = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = AW'(10 + acc);
      #0.5 if (req_ready) begin expq.push_back(shadow[10 + acc]); acc++; end
    end
    @(negedge clk) req_valid = 0;
    check(acc == DEPTH, "R6 outstanding cap", acc, DEPTH);
    #1 check(!req_ready, "R6 ready low when full", req_ready, 0);
    // R5: head answer stays put
    check(rsp_valid && rsp_rdata == expq[0], "R5 head held", rsp_rdata, expq[0]);
    repeat (3) @(negedge clk);
    #1 check(rsp_valid && rsp_rdata == expq[0], "R5 head still held", rsp_rdata, expq[0]);
    // R7: one pop frees a slot in the next cycle
    @(negedge clk) rsp_ready = 1;
    @(negedge clk) rsp_ready = 0;
    #0.5 check(req_ready, "R7 ready returns", req_ready, 1);
    @(negedge clk) rsp_ready = 1;
    repeat (6) @(negedge clk);
    check(expq.size() == 0, "R4 stall drained", expq.size(), 0);

    // R4: mixed stream with irregular answer stalls
    fork
      begin
        for (int i = 0; i < 24; i++) begin
          if (i % 5 == 2) send(1, 4'(i % 16), 32'hC000 + i);
          else send(0, 4'((i * 3) % 16), '0);
        end
      end
      begin
        for (int c = 0; c < 120; c++) begin
          @(negedge clk) rsp_ready = ((c % 3) != 0) && ((c % 7) != 4);
        end
      end
    join
    @(negedge clk) rsp_ready = 1;
    repeat (8) @(negedge clk);
    check(expq.size() == 0, "R4 stream drained", expq.size(), 0);
    check(strobe_bad == 0, "R1 target strobe", strobe_bad, 0);
    check(popped == 31, "R2/R3 answer count", popped, 31);
    summary();
  end
endmodule